// File: doc/BRIEF.md
# Floating-Point Exception and Status Word Unit

This unit keeps the 16-bit control word and assembles the 16-bit status word of a floating-point coprocessor. An external arithmetic unit reports each operation's exceptions as a strobed six-bit pulse vector. The unit records these exceptions in sticky flags. Each flag has its own mask bit in the control word. From the unmasked flags the unit derives an error-summary bit, and that bit drives the external error line to the host. The arithmetic unit also delivers a two-bit comparison result. The unit turns this result into condition-code bits.

The host writes the control word and can issue a clear-exceptions command. It reads the status word through a registered read port. A status read does not touch the busy bit, and it does not wait for the busy bit to clear. The precision and rounding fields of the control word go straight out to the datapath. The busy bit and the stack-top field are supplied from outside and are only placed into the status word.

The reset input is asynchronous and active low. Its release is synchronised inside the unit, so internal state leaves reset two clock edges after the input rises.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset the control word is 16'h033F: all six masks are 1, precision is 2'b11 and rounding is 2'b00. All flags, condition codes, read data and the error output are 0.
- R2: Status bits 5..0 are sticky flags with this bit order: bit0 invalid operation, bit1 denormal operand, bit2 zero divide, bit3 overflow, bit4 underflow, bit5 inexact. On a clock edge where exc_valid is high, each flag ORs in its exc_bits bit. A flag then stays set until a clear.
- R3: A clr_exc pulse clears all flags at the next edge. Exception bits strobed in the same cycle as the clear are kept.
- R4: Status bit 7 is 1 exactly when some flag is set whose control mask bit (control bits 5..0, in the same order as the flags) is 0. err_out always equals status bit 7.
- R5: A control write (ctl_wr) loads all 16 bits at the next edge. In that same cycle the error summary reflects the new masks. The write leaves the flags unchanged. Without ctl_wr the control word holds its value.
- R6: A comparison strobe sets C3, C2, C0 (status bits 14, 10, 8) from cmp_code. Code 0 (greater) gives 000, code 1 (less) gives 001, code 2 (equal) gives 100 and code 3 (unordered) gives 111. C1 (status bit 9) is left unchanged.
- R7: cc_ld loads all four condition bits from cc_din, ordered {C3,C2,C1,C0}. When cc_ld and cmp_valid arrive in the same cycle, cc_ld wins.
- R8: Status bit 15 follows exec_busy. A stat_rd pulse captures the status word into rd_data at the next edge. The read changes neither the busy bit nor any other state.
- R9: prec_sel equals control bits 9..8 and rnd_sel equals control bits 11..10.
- R10: Status bits 13..11 carry top_ptr and status bit 6 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Strobe qualifying exc_bits |
| exc_bits | input | 6 | Exception pulses from the arithmetic unit |
| clr_exc | input | 1 | Clear-exceptions command |
| cmp_valid | input | 1 | Comparison result strobe |
| cmp_code | input | 2 | Comparison result: 0 greater, 1 less, 2 equal, 3 unordered |
| cc_ld | input | 1 | Load all four condition bits |
| cc_din | input | 4 | Condition bits {C3,C2,C1,C0} |
| exec_busy | input | 1 | Execution unit running an instruction |
| top_ptr | input | 3 | Register stack top pointer |
| ctl_wr | input | 1 | Host control word write |
| ctl_wdata | input | 16 | Control word write data |
| stat_rd | input | 1 | Host status word read |
| status_word | output | 16 | Live status word |
| ctl_word | output | 16 | Current control word |
| rd_data | output | 16 | Status word captured by the last read |
| err_out | output | 1 | External error line |
| prec_sel | output | 2 | Precision field for the datapath |
| rnd_sel | output | 2 | Rounding field for the datapath |

## Verification
A flag that is lost or wrongly set shows up on status bits 5..0 one edge after the stimulus. It also reaches err_out on that same edge, as long as the matching mask bit is 0. A mask that decodes wrongly shows up as an error summary that disagrees with the written mask in the cycle after the control write. A bad condition-code update shows up one edge after the strobe, either in C3/C2/C0 or as a changed C1. A read path that disturbs state shows up as a difference between rd_data and the live status word, or between the status word before and after the read.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned N_EXC  = 6;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CC_W   = 4;
  localparam int unsigned TOP_W  = 3;

  localparam logic [WORD_W-1:0] CTL_RST = 16'h033F;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic c3;
    logic c2;
    logic c1;
    logic c0;
  } ccode_t;

  // Returns {C3, C2, C0} for a comparison outcome.
  function automatic logic [2:0] cmp_to_cc(input cmp_res_e r);
    logic [2:0] v;
    case (r)
      CMP_GT:  v = 3'b000;
      CMP_LT:  v = 3'b001;
      CMP_EQ:  v = 3'b100;
      default: v = 3'b111;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fpx_rst_sync.sv
module fpx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fpx_ctl_reg.sv
module fpx_ctl_reg #(
  parameter int unsigned W = fpx_pkg::WORD_W,
  parameter int unsigned N = fpx_pkg::N_EXC,
  parameter logic [W-1:0] RST_VAL = fpx_pkg::CTL_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctl_q,
  output logic [N-1:0] masks,
  output logic [1:0]   prec,
  output logic [1:0]   rnd
);
  localparam int unsigned PREC_LSB = 8;
  localparam int unsigned RND_LSB  = 10;

  logic [W-1:0] ctl_d;
  logic         ctl_en;

  always_comb begin
    ctl_en = wr;
    ctl_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RST_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign masks = ctl_q[N-1:0];
  assign prec  = ctl_q[PREC_LSB+1:PREC_LSB];
  assign rnd   = ctl_q[RND_LSB+1:RND_LSB];

  // R5
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl_q));
  // R5
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctl_q == $past(wdata)));
endmodule

// File: rtl/fpx_flags.sv
module fpx_flags #(
  parameter int unsigned N = fpx_pkg::N_EXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  input  logic [N-1:0] masks,
  output logic [N-1:0] flags,
  output logic         summary
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;
    logic bit_d;
    logic bit_en;
    logic hit;

    always_comb begin
      hit    = set_en & set_vec[i];
      bit_en = clr | hit;
      bit_d  = (clr ? 1'b0 : bit_q) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign flags[i] = bit_q;
  end

  assign summary = |(flags & ~masks);

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_en) |=> (flags == '0));
  // R4
  quiet_no_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !summary);
endmodule

// File: rtl/fpx_ccode.sv
module fpx_ccode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_en,
  input  logic [1:0] cmp_code,
  input  logic       ld_en,
  input  logic [3:0] ld_val,
  output logic [3:0] cc
);
  import fpx_pkg::*;

  ccode_t   cc_q;
  ccode_t   cc_d;
  logic     cc_en;
  logic [2:0] cmp_bits;

  always_comb begin
    cmp_bits = cmp_to_cc(cmp_res_e'(cmp_code));
    cc_en    = ld_en | cmp_en;
    cc_d     = cc_q;
    if (ld_en) begin
      cc_d = ccode_t'(ld_val);
    end else if (cmp_en) begin
      cc_d.c3 = cmp_bits[2];
      cc_d.c2 = cmp_bits[1];
      cc_d.c0 = cmp_bits[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cc_q <= '0;
    else if (cc_en) cc_q <= cc_d;
  end

  assign cc = cc_q;

  // R6
  cmp_keeps_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !ld_en) |=> (cc[1] == $past(cc[1])));
  // R7
  ld_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cc == $past(ld_val)));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !cmp_en) |=> $stable(cc));
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit #(
  parameter int unsigned N_EXC = fpx_pkg::N_EXC,
  parameter int unsigned W     = fpx_pkg::WORD_W,
  parameter int unsigned TOP_W = fpx_pkg::TOP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic [N_EXC-1:0] exc_bits,
  input  logic             clr_exc,
  input  logic             cmp_valid,
  input  logic [1:0]       cmp_code,
  input  logic             cc_ld,
  input  logic [3:0]       cc_din,
  input  logic             exec_busy,
  input  logic [TOP_W-1:0] top_ptr,
  input  logic             ctl_wr,
  input  logic [W-1:0]     ctl_wdata,
  input  logic             stat_rd,
  output logic [W-1:0]     status_word,
  output logic [W-1:0]     ctl_word,
  output logic [W-1:0]     rd_data,
  output logic             err_out,
  output logic [1:0]       prec_sel,
  output logic [1:0]       rnd_sel
);
  logic             rst_s_n;
  logic [N_EXC-1:0] masks;
  logic [N_EXC-1:0] flags;
  logic             summary;
  logic [3:0]       cc;
  logic [W-1:0]     rd_q;
  logic [W-1:0]     rd_d;
  logic             rd_en;

  fpx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  fpx_ctl_reg #(.W(W), .N(N_EXC)) u_ctl (
    .clk   (clk),
    .rst_n (rst_s_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl_q (ctl_word),
    .masks (masks),
    .prec  (prec_sel),
    .rnd   (rnd_sel)
  );

  fpx_flags #(.N(N_EXC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .set_en  (exc_valid),
    .set_vec (exc_bits),
    .clr     (clr_exc),
    .masks   (masks),
    .flags   (flags),
    .summary (summary)
  );

  fpx_ccode u_cc (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cmp_en   (cmp_valid),
    .cmp_code (cmp_code),
    .ld_en    (cc_ld),
    .ld_val   (cc_din),
    .cc       (cc)
  );

  // Layout: 15 busy, 14 C3, 13..11 top, 10 C2, 9 C1, 8 C0, 7 summary, 6 zero, 5..0 flags
  always_comb begin
    status_word        = '0;
    status_word[15]    = exec_busy;
    status_word[14]    = cc[3];
    status_word[13:11] = top_ptr;
    status_word[10]    = cc[2];
    status_word[9]     = cc[1];
    status_word[8]     = cc[0];
    status_word[7]     = summary;
    status_word[N_EXC-1:0] = flags;
  end

  assign err_out = summary;

  always_comb begin
    rd_en = stat_rd;
    rd_d  = status_word;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R8
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    stat_rd |=> (rd_data == $past(status_word)));
  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !stat_rd |=> $stable(rd_data));
  // R10
  spare_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    status_word[6] == 1'b0);
endmodule

// File: tb/fpx_status_unit_test.sv
module fpx_status_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [5:0]  exc_bits;
  logic        clr_exc;
  logic        cmp_valid;
  logic [1:0]  cmp_code;
  logic        cc_ld;
  logic [3:0]  cc_din;
  logic        exec_busy;
  logic [2:0]  top_ptr;
  logic        ctl_wr;
  logic [15:0] ctl_wdata;
  logic        stat_rd;
  logic [15:0] status_word;
  logic [15:0] ctl_word;
  logic [15:0] rd_data;
  logic        err_out;
  logic [1:0]  prec_sel;
  logic [1:0]  rnd_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fpx_status_unit uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_bits(exc_bits),
    .clr_exc(clr_exc), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
    .cc_ld(cc_ld), .cc_din(cc_din), .exec_busy(exec_busy), .top_ptr(top_ptr),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
    .status_word(status_word), .ctl_word(ctl_word), .rd_data(rd_data),
    .err_out(err_out), .prec_sel(prec_sel), .rnd_sel(rnd_sel)
  );

  // Vector: [31] ctl write, [29:24] mask, [23] clear, [21:16] pulses,
  //         [13:8] expected flags, [0] expected error
  localparam logic [31:0] VEC [11] = '{
    32'h0020_2000,  // pulse inexact, masked
    32'hBE00_2000,  // unmask invalid
    32'h0001_2101,  // pulse invalid -> error
    32'h0004_2501,  // pulse zero divide, sticky
    32'h0080_0000,  // clear
    32'h0088_0800,  // clear with overflow pulse kept
    32'hB700_0801,  // unmask overflow
    32'hBF00_0800,  // mask all
    32'h0010_1800,  // pulse underflow
    32'hAF00_1801,  // unmask underflow
    32'h0080_0000   // clear
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_valid = 0; exc_bits = '0; clr_exc = 0; cmp_valid = 0; cmp_code = '0;
    cc_ld = 0; cc_din = '0; ctl_wr = 0; ctl_wdata = '0; stat_rd = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    exec_busy = 0;
    top_ptr   = 3'd0;
    rst_n     = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ctl", ctl_word, 16'h033F);
    chk("R1 status", status_word, 16'h0000);
    chk("R1 err", {15'd0, err_out}, 16'd0);
    chk("R1 rd", rd_data, 16'h0000);

    // Vector walk: R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      ctl_wr    = VEC[i][31];
      ctl_wdata = 16'h0300 | {10'd0, VEC[i][29:24]};
      clr_exc   = VEC[i][23];
      exc_bits  = VEC[i][21:16];
      exc_valid = |VEC[i][21:16];
      step();
      chk("R2/R3 flags", {10'd0, status_word[5:0]}, {10'd0, VEC[i][13:8]});
      chk("R4 err", {15'd0, err_out}, {15'd0, VEC[i][0]});
      chk("R4 summary bit", {15'd0, status_word[7]}, {15'd0, VEC[i][0]});
    end

    // R5/R9: control write with new precision and rounding, flags untouched
    exc_bits = 6'h02; exc_valid = 1; step();
    ctl_wr = 1; ctl_wdata = 16'h0A3F; step();
    chk("R5 ctl", ctl_word, 16'h0A3F);
    chk("R5 flags kept", {10'd0, status_word[5:0]}, 16'h0002);
    chk("R9 prec", {14'd0, prec_sel}, 16'd2);
    chk("R9 rnd", {14'd0, rnd_sel}, 16'd2);
    ctl_wr = 1; ctl_wdata = 16'h0C3D; step();
    chk("R5 unmask denormal err", {15'd0, err_out}, 16'd1);
    chk("R9 rnd trunc", {14'd0, rnd_sel}, 16'd3);
    chk("R9 prec 24", {14'd0, prec_sel}, 16'd0);
    step();
    chk("R5 hold", ctl_word, 16'h0C3D);

    // R7 then R6: set C1, run all compare codes
    cc_ld = 1; cc_din = 4'b0010; step();
    chk("R7 load", {12'd0, status_word[14], status_word[10:8]}, 16'b0010);
    for (int c = 0; c < 4; c++) begin
      logic [2:0] e;
      cmp_valid = 1; cmp_code = c[1:0];
      e = (c == 0) ? 3'b000 : (c == 1) ? 3'b001 : (c == 2) ? 3'b100 : 3'b111;
      step();
      chk("R6 C3C2C0", {13'd0, status_word[14], status_word[10], status_word[8]}, {13'd0, e});
      chk("R6 C1 kept", {15'd0, status_word[9]}, 16'd1);
    end
    cc_ld = 1; cc_din = 4'b0100; cmp_valid = 1; cmp_code = 2'd3; step();
    chk("R7 priority", {12'd0, status_word[14], status_word[10:8]}, 16'b0100);

    // R8 busy and read
    exec_busy = 1; #1;
    chk("R8 busy", {15'd0, status_word[15]}, 16'd1);
    exec_busy = 0; top_ptr = 3'd5;
    stat_rd = 1; step();
    chk("R8 read no busy", {15'd0, rd_data[15]}, 16'd0);
    chk("R8 live no busy", {15'd0, status_word[15]}, 16'd0);
    chk("R8 read matches", rd_data, status_word);
    chk("R10 top", {13'd0, status_word[13:11]}, 16'd5);
    chk("R10 bit6", {15'd0, status_word[6]}, 16'd0);
    exec_busy = 1; stat_rd = 1; step();
    chk("R8 read busy", {15'd0, rd_data[15]}, 16'd1);
    chk("R8 flags kept", {10'd0, status_word[5:0]}, 16'h0002);

    // R1 reset again clears everything
    rst_n = 0; #1;
    chk("R1 async ctl", ctl_word, 16'h033F);
    chk("R1 async flags", {10'd0, status_word[5:0]}, 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule